// File: doc/BRIEF.md
# Banked Translation Control and Fallback Attribute Resolver

This block keeps the system control word that governs address translation in two banked copies: one for the Secure world and one for the Non-secure world. Software writes a copy through a write port, and a security-state input chooses which copy is written. A read port returns either copy one cycle after the request.

On every cycle the block also resolves one memory access. It takes the world of the access, whether the access is an instruction fetch or a data access, and two remap attribute words. From these it reports three things:

- whether translation is enabled for that world;
- whether the data cache is effectively enabled;
- when translation is off, the memory type the access receives.

Page-table walks, TLB storage and the caches are outside this block. Toggling the translation enable never produces any invalidate or flush indication, because the block has no such output.

Top module: `mmu_attr_top`

## Requirements
- R1: After synchronous reset, both control copies are zero. A read of either copy returns zero, and `xlat_on`, `dcache_on` and `mem_type` are 0.
- R2: A write with `wr_secure`=1 updates only the Secure copy. A write with `wr_secure`=0 updates only the Non-secure copy. The other copy keeps its value.
- R3: A write takes effect at the clock edge that samples it. A read sampled at the same edge returns the old value. `rd_data` appears one cycle after `rd_secure` is sampled.
- R4: `xlat_on` equals bit 0 (translation enable) of the copy chosen by `acc_secure`. It is registered: it reflects the inputs sampled one edge earlier.
- R5: While translation is on for the access world, `mem_type` reads 00.
- R6: Memory types are coded as 00 strongly ordered, 01 device, 10 normal non-cacheable and 11 normal cacheable. With translation off and bit 28 (remap enable) clear, a data access gets 00 whatever the value of bit 2 (data cache enable).
- R7: With translation off and bit 28 clear, an instruction fetch gets 11 if bit 12 (instruction cache enable) is 1, and 00 if it is 0.
- R8: With translation off and bit 28 set, the type is taken from `remap_pri[1:0]`, for both fetches and data and regardless of bits 2 and 12. Values 00 and 01 pass through unchanged. Values 10 and 11 give 11 if `remap_nrm[1:0]` is nonzero, and 10 otherwise.
- R9: `dcache_on` is 1 only when both bit 0 and bit 2 of the access world's copy are 1. It is 0 whenever translation is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_secure | input | 1 | Selects the copy to write: 1 Secure, 0 Non-secure |
| wr_data | input | 32 | Value to write |
| rd_secure | input | 1 | Selects the copy to read |
| rd_data | output | 32 | Registered read value |
| acc_secure | input | 1 | World of the current access |
| acc_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| remap_pri | input | 32 | Primary remap attribute word |
| remap_nrm | input | 32 | Normal-memory remap attribute word |
| xlat_on | output | 1 | Translation enabled for the access world |
| dcache_on | output | 1 | Data cache effectively enabled for the access world |
| mem_type | output | 2 | Memory type for the access when translation is off |

## Verification
Every result comes from one register stage, but the timing differs by operation:

- A read returns `rd_data` at the first edge after the request.
- Access attributes appear at the first edge after the access inputs are sampled.
- A write becomes visible to reads and accesses one edge after the write edge.

The bench drives all inputs on the falling edge and samples on the next falling edge, so each check sees exactly one rising edge between stimulus and result. The write-versus-read collision is checked by sampling `rd_data` on the falling edge right after the write edge, where the old value is expected, and then again one cycle later, where the new value is expected.

// File: rtl/mmu_attr_pkg.sv
package mmu_attr_pkg;
  typedef enum logic [1:0] {
    MT_STRONG = 2'b00,
    MT_DEVICE = 2'b01,
    MT_NORM_NC = 2'b10,
    MT_NORM_C = 2'b11
  } mem_type_e;

  localparam int NUM_WORLDS = 2;
endpackage

// File: rtl/ctl_bank.sv
module ctl_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sec,
  input  logic [W-1:0] wr_data,
  input  logic         rd_sec,
  output logic [W-1:0] rd_data,
  input  logic         acc_sec,
  output logic [W-1:0] acc_ctl
);
  import mmu_attr_pkg::*;

  logic [W-1:0] bank_q [NUM_WORLDS];

  for (genvar g = 0; g < NUM_WORLDS; g++) begin : g_world
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q[g] <= '0;
      end else if (wr_en && (wr_sec == g[0])) begin
        bank_q[g] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= bank_q[rd_sec];
  end

  assign acc_ctl = bank_q[acc_sec];

  // R1
  bank_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (bank_q[0] == '0 && bank_q[1] == '0));

  // R2
  ns_write_keeps_sec_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sec) |=> bank_q[1] == $past(bank_q[1]));

  // R2
  sec_write_keeps_ns_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sec) |=> bank_q[0] == $past(bank_q[0]));
endmodule

// File: rtl/attr_resolve.sv
module attr_resolve #(
  parameter int W       = 32,
  parameter int M_BIT   = 0,
  parameter int C_BIT   = 2,
  parameter int I_BIT   = 12,
  parameter int TRE_BIT = 28,
  parameter int PRI_LSB = 0,
  parameter int NRM_LSB = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ctl,
  input  logic         is_fetch,
  input  logic [W-1:0] remap_pri,
  input  logic [W-1:0] remap_nrm,
  output logic         xlat_on,
  output logic         dcache_on,
  output logic [1:0]   mem_type
);
  import mmu_attr_pkg::*;

  localparam int FW = 2;

  logic [FW-1:0] pri_f, nrm_f;
  mem_type_e remap_type, legacy_type, next_type;
  logic unused_bits;

  assign pri_f = remap_pri[PRI_LSB +: FW];
  assign nrm_f = remap_nrm[NRM_LSB +: FW];
  assign unused_bits = ^{remap_pri, remap_nrm, ctl};

  always_comb begin
    if (pri_f[1])
      remap_type = (nrm_f != '0) ? MT_NORM_C : MT_NORM_NC;
    else
      remap_type = mem_type_e'(pri_f);

    if (is_fetch && ctl[I_BIT])
      legacy_type = MT_NORM_C;
    else
      legacy_type = MT_STRONG;

    if (ctl[M_BIT])        next_type = MT_STRONG;
    else if (ctl[TRE_BIT]) next_type = remap_type;
    else                   next_type = legacy_type;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xlat_on   <= 1'b0;
      dcache_on <= 1'b0;
      mem_type  <= MT_STRONG;
    end else begin
      xlat_on   <= ctl[M_BIT];
      dcache_on <= ctl[M_BIT] & ctl[C_BIT];
      mem_type  <= next_type;
    end
  end

  // R6
  legacy_data_strong_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl[M_BIT] && !ctl[TRE_BIT] && !is_fetch) |=> mem_type == MT_STRONG);

  // R7
  legacy_fetch_icache_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl[M_BIT] && !ctl[TRE_BIT] && is_fetch && ctl[I_BIT]) |=> mem_type == MT_NORM_C);

  // R5
  on_type_zero_chk: assert property (@(posedge clk) disable iff (rst)
    xlat_on |-> mem_type == MT_STRONG);

  // R9
  dcache_needs_xlat_chk: assert property (@(posedge clk) disable iff (rst)
    dcache_on |-> xlat_on);
endmodule

// File: rtl/mmu_attr_top.sv
module mmu_attr_top #(
  parameter int W       = 32,
  parameter int M_BIT   = 0,
  parameter int C_BIT   = 2,
  parameter int I_BIT   = 12,
  parameter int TRE_BIT = 28,
  parameter int PRI_LSB = 0,
  parameter int NRM_LSB = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_secure,
  input  logic [W-1:0] wr_data,
  input  logic         rd_secure,
  output logic [W-1:0] rd_data,
  input  logic         acc_secure,
  input  logic         acc_fetch,
  input  logic [W-1:0] remap_pri,
  input  logic [W-1:0] remap_nrm,
  output logic         xlat_on,
  output logic         dcache_on,
  output logic [1:0]   mem_type
);
  logic [W-1:0] acc_ctl;

  ctl_bank #(.W(W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sec  (wr_secure),
    .wr_data (wr_data),
    .rd_sec  (rd_secure),
    .rd_data (rd_data),
    .acc_sec (acc_secure),
    .acc_ctl (acc_ctl)
  );

  attr_resolve #(
    .W(W), .M_BIT(M_BIT), .C_BIT(C_BIT), .I_BIT(I_BIT),
    .TRE_BIT(TRE_BIT), .PRI_LSB(PRI_LSB), .NRM_LSB(NRM_LSB)
  ) u_resolve (
    .clk       (clk),
    .rst       (rst),
    .ctl       (acc_ctl),
    .is_fetch  (acc_fetch),
    .remap_pri (remap_pri),
    .remap_nrm (remap_nrm),
    .xlat_on   (xlat_on),
    .dcache_on (dcache_on),
    .mem_type  (mem_type)
  );
endmodule

// File: tb/tb_mmu_attr_top.sv
module tb_mmu_attr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_secure = 1'b0, rd_secure = 1'b0;
  logic [31:0] wr_data = '0, remap_pri = '0, remap_nrm = '0;
  logic        acc_secure = 1'b0, acc_fetch = 1'b0;
  logic [31:0] rd_data;
  logic        xlat_on, dcache_on;
  logic [1:0]  mem_type;

  int n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  mmu_attr_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_secure(wr_secure), .wr_data(wr_data),
    .rd_secure(rd_secure), .rd_data(rd_data), .acc_secure(acc_secure),
    .acc_fetch(acc_fetch), .remap_pri(remap_pri), .remap_nrm(remap_nrm),
    .xlat_on(xlat_on), .dcache_on(dcache_on), .mem_type(mem_type)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctl(input int idx);
    logic [31:0] v;
    v = 32'h0000_0040;
    v[0]  = idx[0];
    v[2]  = idx[1];
    v[12] = idx[2];
    v[28] = idx[3];
    return v;
  endfunction

  function automatic logic [1:0] exp_type(input logic [31:0] c, input logic f,
                                          input logic [1:0] p, input logic [1:0] n);
    if (c[0]) return 2'b00;
    if (c[28]) begin
      if (p < 2) return p;
      return (n != 0) ? 2'b11 : 2'b10;
    end
    if (f && c[12]) return 2'b11;
    return 2'b00;
  endfunction

  task automatic do_write(input logic sec, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_secure = sec; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd_secure = 1'b0;
    @(negedge clk);
    check("R1 ns copy", rd_data, 32'h0);
    check("R1 xlat", {31'b0, xlat_on}, 0);
    check("R1 dcache", {31'b0, dcache_on}, 0);
    check("R1 type", {30'b0, mem_type}, 0);
    rd_secure = 1'b1;
    @(negedge clk);
    check("R1 sec copy", rd_data, 32'h0);

    // R3: read in same cycle as write returns old value
    do_write(1'b1, 32'h1234_5670);
    @(negedge clk);
    rd_secure = 1'b1;
    wr_en = 1'b1; wr_secure = 1'b1; wr_data = 32'hCAFE_0000;
    @(negedge clk);
    wr_en = 1'b0;
    check("R3 old on collision", rd_data, 32'h1234_5670);
    @(negedge clk);
    check("R3 new after edge", rd_data, 32'hCAFE_0000);

    // Exhaustive sweep
    for (int w = 0; w < 2; w++) begin
      for (int ci = 0; ci < 16; ci++) begin
        logic [31:0] mine, other;
        mine  = mk_ctl(ci);
        other = mk_ctl(15 - ci) ^ 32'h0000_0100;
        do_write(w[0], mine);
        do_write(~w[0], other);
        @(negedge clk);
        rd_secure = w[0];
        @(negedge clk);
        check("R2 own copy", rd_data, mine);
        rd_secure = ~w[0];
        @(negedge clk);
        check("R2 other copy", rd_data, other);
        acc_secure = w[0];
        for (int f = 0; f < 2; f++) begin
          for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
              acc_fetch = f[0];
              remap_pri = 32'hFFFF_FFF0 | p;
              remap_nrm = 32'h0000_FFFC | n;
              @(negedge clk);
              check("R4 xlat_on", {31'b0, xlat_on}, {31'b0, mine[0]});
              check("R9 dcache_on", {31'b0, dcache_on}, {31'b0, mine[0] & mine[2]});
              if (mine[0])
                check("R5 type when on", {30'b0, mem_type}, 0);
              else if (mine[28])
                check("R8 remap type", {30'b0, mem_type},
                      {30'b0, exp_type(mine, f[0], p[1:0], n[1:0])});
              else if (f == 0)
                check("R6 data type", {30'b0, mem_type}, 0);
              else
                check("R7 fetch type", {30'b0, mem_type},
                      {30'b0, exp_type(mine, 1'b1, p[1:0], n[1:0])});
            end
          end
        end
      end
    end

    // R4 latency: switch access world, result follows after one edge
    do_write(1'b1, 32'h1);
    do_write(1'b0, 32'h0);
    @(negedge clk);
    acc_secure = 1'b1;
    @(negedge clk);
    check("R4 sec world on", {31'b0, xlat_on}, 1);
    acc_secure = 1'b0;
    @(negedge clk);
    check("R4 ns world off", {31'b0, xlat_on}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule